// File: doc/BRIEF.md
# ALU Micro-Operation Control Latch

This block sits between a microcode sequencer and a 16-bit ALU. Configuring the ALU and collecting its result are issued by different micro-instructions, so the block captures the ALU micro-operation when it is issued. It holds that operation until a later micro-instruction reads the result. Each ALU micro-operation carries a 5-bit operation code and a 2-bit field that picks one of three temporary registers. The block drives the latched code, a one-hot enable for the temporary registers, and a set of decoded group strobes that the ALU uses for its special cases.

One operation code, 0x11, is a pseudo-operation: "use the operation the machine instruction names". When it is latched, the stored code is assembled from instruction bits. The low three bits come from an X register that captured instruction bits 5..3. Bit 3 comes from instruction bit 6. Bit 4 comes from a group-decode input. The machine-instruction sequencer raises a second-byte event for every new instruction. This event returns the state to ADD with temporary register A, so a plain add needs no configuring micro-operation. The event comes on the second byte and not the first, because the previous micro-instruction may still be completing during the first.

Top module: `uop_alu_ctl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no other input active, `op_out` is 0x00 (ADD) and `tmp_en` is 3'b001 (register A).
- R2: When `alu_en` is high and `op_field` is not 0x11, `op_out` shows `op_field` from the next clock edge.
- R3: When `alu_en` is high and `op_field` is 0x11, the latched code is {`grp_bit`, `ir_b6`, X register[2:0]}, where bit 4 is `grp_bit`.
- R4: A high `x_load` copies `x_src` (instruction bits 5..3) into the X register at the clock edge. A pseudo-operation latched on that same edge still uses the previous X value.
- R5: When `alu_en` is high, `tmp_field` 2'b00 selects A (`tmp_en`=3'b001), 2'b01 selects B (3'b010) and 2'b10 selects C (3'b100), from the next edge.
- R6: A `tmp_field` of 2'b11 leaves `tmp_en` unchanged, even while the operation code is being latched.
- R7: While `alu_en` and `second_byte` are low, `op_out` and `tmp_en` hold their values for any number of cycles.
- R8: A high `second_byte` sets `op_out` to 0x00 and `tmp_en` to 3'b001 at the next edge, and it takes priority over `alu_en` in the same cycle.
- R9: `tmp_en` has exactly one bit set at all times after reset.
- R10: `grp_lshift` is high exactly for `op_out` in {0x08, 0x0A, 0x0C, 0x0E}, and `grp_rshift` is high exactly for {0x09, 0x0B, 0x0D, 0x0F}. Both strobes follow `op_out` in the same cycle.
- R11: `grp_sub` is high exactly for `op_out` in {0x05, 0x07, 0x15, 0x17}, and `grp_dec` is high exactly for {0x19, 0x1D}.
- R12: `grp_add` is high exactly for `op_out` in {0x00, 0x02}, and `grp_cmpl` is high exactly for {0x1A, 0x1B}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_load | input | 1 | Strobe that loads the X register |
| x_src | input | 3 | Instruction bits 5..3 captured by the X register |
| ir_b6 | input | 1 | Instruction bit 6, used as bit 3 of a substituted code |
| grp_bit | input | 1 | Group-decode bit, used as bit 4 of a substituted code |
| second_byte | input | 1 | New-instruction second-byte event, which clears to ADD and register A |
| alu_en | input | 1 | The current micro-instruction carries an ALU operation |
| op_field | input | 5 | Operation field of the micro-instruction |
| tmp_field | input | 2 | Temporary-register field of the micro-instruction |
| op_out | output | 5 | Latched operation code |
| tmp_en | output | 3 | One-hot temporary-register enable (bit 0 is A) |
| grp_lshift | output | 1 | Left-shift group strobe |
| grp_rshift | output | 1 | Right-shift group strobe |
| grp_sub | output | 1 | Subtract-type group strobe |
| grp_dec | output | 1 | Decrement group strobe |
| grp_add | output | 1 | Add group strobe |
| grp_cmpl | output | 1 | Complement group strobe |

## Verification
The bench builds the block with its default parameters: three temporary registers and the pseudo-operation at 0x11. With these values, all 32 operation codes can be swept and every strobe compared with sets that the bench writes out itself. All four temporary-field codes, including the reserved one, are also within reach. The defaults also allow the cases where two events share a clock edge to be set up directly: an X-register load together with a substitution, and a second-byte event together with an ALU micro-operation.

// File: rtl/uop_alu_ctl_pkg.sv
package uop_alu_ctl_pkg;
  localparam int OP_W = 5;
  localparam int XR_W = 3;
  typedef logic [OP_W-1:0] op_t;

  localparam op_t OP_ADD   = 5'h00;
  localparam op_t OP_ADC   = 5'h02;
  localparam op_t OP_SUB   = 5'h05;
  localparam op_t OP_CMP   = 5'h07;
  localparam op_t OP_ROL   = 5'h08;
  localparam op_t OP_ROR   = 5'h09;
  localparam op_t OP_RCL   = 5'h0A;
  localparam op_t OP_RCR   = 5'h0B;
  localparam op_t OP_SHL   = 5'h0C;
  localparam op_t OP_SHR   = 5'h0D;
  localparam op_t OP_SETMO = 5'h0E;
  localparam op_t OP_SAR   = 5'h0F;
  localparam op_t OP_DADJS = 5'h15;
  localparam op_t OP_AADJS = 5'h17;
  localparam op_t OP_DEC   = 5'h19;
  localparam op_t OP_COM1  = 5'h1A;
  localparam op_t OP_NEG   = 5'h1B;
  localparam op_t OP_DEC2  = 5'h1D;

  typedef struct packed {
    logic lshift;
    logic rshift;
    logic sub;
    logic dec;
    logic add;
    logic cmpl;
  } grp_t;

  // Assemble the instruction-defined operation code.
  function automatic op_t fill_pseudo(logic g, logic b6, logic [XR_W-1:0] x);
    return {g, b6, x};
  endfunction

  // Decode a latched operation code into its group strobes.
  function automatic grp_t decode_groups(op_t op);
    grp_t g;
    g = '0;
    unique case (op)
      OP_ROL, OP_RCL, OP_SHL, OP_SETMO: g.lshift = 1'b1;
      OP_ROR, OP_RCR, OP_SHR, OP_SAR:   g.rshift = 1'b1;
      OP_SUB, OP_CMP, OP_DADJS, OP_AADJS: g.sub = 1'b1;
      OP_DEC, OP_DEC2:                  g.dec = 1'b1;
      OP_ADD, OP_ADC:                   g.add = 1'b1;
      OP_COM1, OP_NEG:                  g.cmpl = 1'b1;
      default: g = '0;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/uop_xsub.sv
module uop_xsub
  import uop_alu_ctl_pkg::*;
#(
  parameter op_t PSEUDO_OP = 5'h11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            x_load,
  input  logic [XR_W-1:0] x_src,
  input  logic            ir_b6,
  input  logic            grp_bit,
  input  op_t             op_field,
  output logic [XR_W-1:0] x_q,
  output logic            is_pseudo,
  output op_t             op_next
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      x_q <= '0;
    else if (x_load) x_q <= x_src;
  end

  assign is_pseudo = (op_field == PSEUDO_OP);

  always_comb begin
    if (is_pseudo) op_next = fill_pseudo(grp_bit, ir_b6, x_q);
    else           op_next = op_field;
  end
endmodule

// File: rtl/uop_oplatch.sv
module uop_oplatch
  import uop_alu_ctl_pkg::*;
#(
  parameter int N_TMP = 3,
  localparam int TSEL_W = $clog2(N_TMP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  op_t               op_next,
  input  logic [TSEL_W-1:0] tmp_field,
  output op_t               op_q,
  output logic [N_TMP-1:0]  tmp_q
);
  logic tmp_valid;
  assign tmp_valid = (tmp_field < TSEL_W'(N_TMP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    op_q <= OP_ADD;
    else if (clr)  op_q <= OP_ADD;
    else if (load) op_q <= op_next;
  end

  for (genvar i = 0; i < N_TMP; i++) begin : g_tmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    tmp_q[i] <= (i == 0);
      else if (clr)                  tmp_q[i] <= (i == 0);
      else if (load && tmp_valid)    tmp_q[i] <= (tmp_field == TSEL_W'(i));
    end
  end
endmodule

// File: rtl/uop_grpdec.sv
module uop_grpdec
  import uop_alu_ctl_pkg::*;
(
  input  op_t  op_q,
  output grp_t grp
);
  assign grp = decode_groups(op_q);
endmodule

// File: rtl/uop_alu_ctl.sv
module uop_alu_ctl
  import uop_alu_ctl_pkg::*;
#(
  parameter int  N_TMP     = 3,
  parameter op_t PSEUDO_OP = 5'h11,
  localparam int TSEL_W    = $clog2(N_TMP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              x_load,
  input  logic [XR_W-1:0]   x_src,
  input  logic              ir_b6,
  input  logic              grp_bit,
  input  logic              second_byte,
  input  logic              alu_en,
  input  logic [OP_W-1:0]   op_field,
  input  logic [TSEL_W-1:0] tmp_field,
  output logic [OP_W-1:0]   op_out,
  output logic [N_TMP-1:0]  tmp_en,
  output logic              grp_lshift,
  output logic              grp_rshift,
  output logic              grp_sub,
  output logic              grp_dec,
  output logic              grp_add,
  output logic              grp_cmpl
);
  logic [XR_W-1:0] x_q;
  logic            is_pseudo;
  op_t             op_next;
  grp_t            grp;

  uop_xsub #(.PSEUDO_OP(PSEUDO_OP)) u_xsub (
    .clk(clk), .rst_n(rst_n), .x_load(x_load), .x_src(x_src),
    .ir_b6(ir_b6), .grp_bit(grp_bit), .op_field(op_field),
    .x_q(x_q), .is_pseudo(is_pseudo), .op_next(op_next)
  );

  uop_oplatch #(.N_TMP(N_TMP)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr(second_byte), .load(alu_en),
    .op_next(op_next), .tmp_field(tmp_field),
    .op_q(op_out), .tmp_q(tmp_en)
  );

  uop_grpdec u_dec (.op_q(op_out), .grp(grp));

  assign grp_lshift = grp.lshift;
  assign grp_rshift = grp.rshift;
  assign grp_sub    = grp.sub;
  assign grp_dec    = grp.dec;
  assign grp_add    = grp.add;
  assign grp_cmpl   = grp.cmpl;
endmodule

// File: rtl/uop_alu_ctl_chk.sv
module uop_alu_ctl_chk
  import uop_alu_ctl_pkg::*;
#(
  parameter int  N_TMP     = 3,
  parameter op_t PSEUDO_OP = 5'h11,
  localparam int TSEL_W    = $clog2(N_TMP + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              second_byte,
  input logic              alu_en,
  input logic [OP_W-1:0]   op_field,
  input logic [TSEL_W-1:0] tmp_field,
  input logic              ir_b6,
  input logic              grp_bit,
  input logic [XR_W-1:0]   x_q,
  input logic [OP_W-1:0]   op_out,
  input logic [N_TMP-1:0]  tmp_en,
  input logic [5:0]        grp_vec
);
  a_r2_plain_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && !second_byte && op_field != PSEUDO_OP) |=> op_out == $past(op_field));

  a_r3_pseudo_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && !second_byte && op_field == PSEUDO_OP)
      |=> op_out == {$past(grp_bit), $past(ir_b6), $past(x_q)});

  a_r6_tmp_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && !second_byte && tmp_field >= TSEL_W'(N_TMP)) |=> $stable(tmp_en));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_en && !second_byte) |=> ($stable(op_out) && $stable(tmp_en)));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    second_byte |=> (op_out == '0 && tmp_en == N_TMP'(1)));

  a_r9_tmp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tmp_en) == 1);

  // R10 R11 R12: the strobe groups never overlap
  a_r10_groups_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_vec));
endmodule

bind uop_alu_ctl uop_alu_ctl_chk #(.N_TMP(N_TMP), .PSEUDO_OP(PSEUDO_OP)) u_chk (
  .clk(clk), .rst_n(rst_n), .second_byte(second_byte), .alu_en(alu_en),
  .op_field(op_field), .tmp_field(tmp_field), .ir_b6(ir_b6), .grp_bit(grp_bit),
  .x_q(x_q), .op_out(op_out), .tmp_en(tmp_en),
  .grp_vec({grp_lshift, grp_rshift, grp_sub, grp_dec, grp_add, grp_cmpl})
);

// File: tb/uop_alu_ctl_tb.sv
module uop_alu_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       x_load = 1'b0;
  logic [2:0] x_src = '0;
  logic       ir_b6 = 1'b0;
  logic       grp_bit = 1'b0;
  logic       second_byte = 1'b0;
  logic       alu_en = 1'b0;
  logic [4:0] op_field = '0;
  logic [1:0] tmp_field = '0;
  logic [4:0] op_out;
  logic [2:0] tmp_en;
  logic grp_lshift, grp_rshift, grp_sub, grp_dec, grp_add, grp_cmpl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uop_alu_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .x_load(x_load), .x_src(x_src), .ir_b6(ir_b6),
    .grp_bit(grp_bit), .second_byte(second_byte), .alu_en(alu_en),
    .op_field(op_field), .tmp_field(tmp_field), .op_out(op_out), .tmp_en(tmp_en),
    .grp_lshift(grp_lshift), .grp_rshift(grp_rshift), .grp_sub(grp_sub),
    .grp_dec(grp_dec), .grp_add(grp_add), .grp_cmpl(grp_cmpl)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one clock edge; returns at the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    alu_en = 1'b0; second_byte = 1'b0; x_load = 1'b0;
  endtask

  task automatic issue(input logic [4:0] op, input logic [1:0] t);
    alu_en = 1'b1; op_field = op; tmp_field = t;
    step();
    idle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(op_out == 5'h00, "R1 op in reset", op_out, 0);
    check(tmp_en == 3'b001, "R1 tmp in reset", tmp_en, 1);
    rst_n = 1'b1;
    step();
    check(op_out == 5'h00 && tmp_en == 3'b001, "R1 after release",
          {tmp_en, op_out}, {3'b001, 5'h00});
  endtask

  task automatic t_plain();
    issue(5'h06, 2'b01);
    check(op_out == 5'h06, "R2 latch 0x06", op_out, 5'h06);
    check(tmp_en == 3'b010, "R5 tmp B", tmp_en, 3'b010);
    issue(5'h1C, 2'b10);
    check(op_out == 5'h1C, "R2 latch 0x1C", op_out, 5'h1C);
    check(tmp_en == 3'b100, "R5 tmp C", tmp_en, 3'b100);
    issue(5'h03, 2'b00);
    check(tmp_en == 3'b001, "R5 tmp A", tmp_en, 3'b001);
  endtask

  task automatic t_pseudo();
    x_load = 1'b1; x_src = 3'b101;
    step();
    idle();
    ir_b6 = 1'b1; grp_bit = 1'b0;
    issue(5'h11, 2'b00);
    check(op_out == 5'h0D, "R3 fill g0 b1 x101", op_out, 5'h0D);
    x_load = 1'b1; x_src = 3'b011;
    step();
    idle();
    ir_b6 = 1'b1; grp_bit = 1'b1;
    issue(5'h11, 2'b00);
    check(op_out == 5'h1B, "R3 fill g1 b1 x011", op_out, 5'h1B);
  endtask

  task automatic t_xreg_timing();
    x_load = 1'b1; x_src = 3'b101;
    step();
    idle();
    ir_b6 = 1'b0; grp_bit = 1'b0;
    x_load = 1'b1; x_src = 3'b010;
    alu_en = 1'b1; op_field = 5'h11; tmp_field = 2'b00;
    step();
    idle();
    check(op_out == 5'h05, "R4 same-edge uses old X", op_out, 5'h05);
    issue(5'h11, 2'b00);
    check(op_out == 5'h02, "R4 new X after load", op_out, 5'h02);
  endtask

  task automatic t_reserved_tmp();
    issue(5'h04, 2'b10);
    issue(5'h0C, 2'b11);
    check(tmp_en == 3'b100, "R6 code 11 keeps C", tmp_en, 3'b100);
    check(op_out == 5'h0C, "R6 op still latched", op_out, 5'h0C);
  endtask

  task automatic t_hold();
    issue(5'h1D, 2'b01);
    op_field = 5'h0A; tmp_field = 2'b10;
    for (int i = 0; i < 3; i++) begin
      step();
      check(op_out == 5'h1D && tmp_en == 3'b010, "R7 hold",
            {tmp_en, op_out}, {3'b010, 5'h1D});
    end
  endtask

  task automatic t_clear();
    issue(5'h0C, 2'b10);
    second_byte = 1'b1; alu_en = 1'b1; op_field = 5'h06; tmp_field = 2'b01;
    step();
    idle();
    check(op_out == 5'h00, "R8 clear op, priority", op_out, 0);
    check(tmp_en == 3'b001, "R8 clear tmp, priority", tmp_en, 1);
    check($countones(tmp_en) == 1, "R9 one-hot", tmp_en, 1);
  endtask

  task automatic t_strobes();
    for (int c = 0; c < 32; c++) begin
      logic [4:0] k;
      logic [5:0] exp_v, act_v;
      if (c == 'h11) continue;
      k = 5'(c);
      issue(k, 2'b11);
      exp_v = {k inside {5'h08, 5'h0A, 5'h0C, 5'h0E},
               k inside {5'h09, 5'h0B, 5'h0D, 5'h0F},
               k inside {5'h05, 5'h07, 5'h15, 5'h17},
               k inside {5'h19, 5'h1D},
               k inside {5'h00, 5'h02},
               k inside {5'h1A, 5'h1B}};
      act_v = {grp_lshift, grp_rshift, grp_sub, grp_dec, grp_add, grp_cmpl};
      check(act_v[5:4] == exp_v[5:4], "R10 shift strobes", act_v[5:4], exp_v[5:4]);
      check(act_v[3:2] == exp_v[3:2], "R11 sub/dec strobes", act_v[3:2], exp_v[3:2]);
      check(act_v[1:0] == exp_v[1:0], "R12 add/cmpl strobes", act_v[1:0], exp_v[1:0]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_plain();
    t_pseudo();
    t_xreg_timing();
    t_reserved_tmp();
    t_hold();
    t_clear();
    t_strobes();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule